// File: doc/BRIEF.md
# Chip-Select Output Controller

This block drives a bank of general-purpose output pins, each of which can be turned into a chip select. Every pin has a stored output level, called its latch. A configuration register holds two bits for each pin. The first turns the pin into a chip select. The second inverts the pin's polarity, and it only takes effect while the pin is a chip select.

A second register is write-only and changes the latches without a read-modify-write. In one word, the upper half holds a set bit for each pin and the lower half holds a clear bit for each pin. A status port always returns the level currently driven on every pin.

After reset every latch holds one and the configuration is zero, so all pins start high. A write of all set bits and no clear bits (0xFF00 with eight pins) drives every latch high, which is the idle state for active-low selects.

Top module: `cs_out_ctrl`

## Requirements
- R1: After reset all latches are 1 and the configuration is 0, so every pin and every status bit reads 1.
- R2: A write with `wr_sel`=1 sets latch i when data bit 8+i is 1 and data bit i is 0.
- R3: A write with `wr_sel`=1 clears latch i when data bit i is 1. A latch whose two bits are both 0 keeps its value.
- R4: When set bit 8+i and clear bit i are both 1 in one write, latch i is cleared.
- R5: When configuration bit 8+i (chip-select mode) is 1, pin i drives latch i XOR configuration bit i (invert).
- R6: When configuration bit 8+i is 0, pin i drives latch i unchanged, whatever configuration bit i holds.
- R7: A write with `wr_sel`=0 replaces all 16 configuration bits and leaves the latches unchanged.
- R8: Bit i of `status` equals the level on pin i.
- R9: In a cycle with `wr_en`=0, no latch, configuration bit or pin changes.
- R10: A write with `wr_sel`=1 leaves the configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 selects the configuration register, 1 selects the set/clear register |
| wr_data | input | 2*NPIN | Write data: upper half is per-pin chip-select enable or set, lower half is per-pin invert or clear |
| status | output | NPIN | Current pin levels |
| pin_out | output | NPIN | Driven output pins |

## Verification
Latch writes are tried with these patterns:
- clear-all
- sparse set
- set and clear on the same pins, which separates clear-wins from set-wins

Configuration patterns are then layered on a fixed latch value:
- invert with no chip-select enable, which shows the invert bit is gated
- enable with no invert
- both bits on all pins
- both bits on one nibble only, which exposes a swapped per-pin index

Directed checks cover the reset levels, holding without a write, and a reset in mid-run that must restore the latches and drop the configuration.

// File: rtl/cs_out_ctrl.sv
module cs_out_ctrl #(
  parameter int NPIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [2*NPIN-1:0] wr_data,
  output logic [NPIN-1:0]   status,
  output logic [NPIN-1:0]   pin_out
);
  logic [NPIN-1:0] lat_q;
  logic [NPIN-1:0] csen_q;
  logic [NPIN-1:0] inv_q;

  wire [NPIN-1:0] set_b = wr_data[2*NPIN-1:NPIN];
  wire [NPIN-1:0] clr_b = wr_data[NPIN-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q  <= '1;
      csen_q <= '0;
      inv_q  <= '0;
    end else if (wr_en) begin
      if (wr_sel) begin
        lat_q <= (lat_q | set_b) & ~clr_b;
      end else begin
        csen_q <= set_b;
        inv_q  <= clr_b;
      end
    end
  end

  assign pin_out = lat_q ^ (inv_q & csen_q);
  assign status  = pin_out;
endmodule

// File: rtl/cs_out_ctrl_chk.sv
module cs_out_ctrl_chk #(
  parameter int NPIN = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [2*NPIN-1:0] wr_data,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   lat_q,
  input logic [NPIN-1:0]   csen_q,
  input logic [NPIN-1:0]   inv_q
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pin_out));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> ((lat_q & $past(wr_data[NPIN-1:0])) == '0));

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=>
      ((~lat_q & $past(wr_data[2*NPIN-1:NPIN] & ~wr_data[NPIN-1:0])) == '0));

  p_cfg_keeps_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> $stable(lat_q));

  p_sc_keeps_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> ($stable(csen_q) && $stable(inv_q)));
endmodule

bind cs_out_ctrl cs_out_ctrl_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .pin_out(pin_out), .lat_q(lat_q),
  .csen_q(csen_q), .inv_q(inv_q)
);

// File: tb/cs_out_ctrl_tb.sv
module cs_out_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  status;
  logic [7:0]  pin_out;
  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  cs_out_ctrl #(.NPIN(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .status(status), .pin_out(pin_out)
  );

  // {sel, data, expected pins}
  localparam int NV = 9;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 16'h00FF, 8'h00},  // R3 clear all
    {1'b1, 16'hA500, 8'hA5},  // R2 sparse set
    {1'b1, 16'h0F0F, 8'hA0},  // R4 clear wins
    {1'b0, 16'hF00F, 8'hA0},  // R6 invert ignored, R7
    {1'b0, 16'hFFFF, 8'h5F},  // R5 all inverted
    {1'b1, 16'h0300, 8'h5C},  // R2 R10 config kept
    {1'b0, 16'h0F0F, 8'hAC},  // R5 low nibble
    {1'b0, 16'hF0F0, 8'h53},  // R5 high nibble
    {1'b1, 16'hFF00, 8'h0F}   // R2 all set
  };

  task automatic check(input string req, input logic [7:0] exp);
    n_run++;
    if (pin_out !== exp || status !== exp) begin
      n_fail++;
      $display("FAIL %s pins=%h status=%h expected=%h", req, pin_out, status, exp);
    end
  endtask

  task automatic do_wr(input logic sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 8'hFF);
    for (int i = 0; i < NV; i++) begin
      do_wr(VEC[i][24], VEC[i][23:8]);
      check($sformatf("vec%0d R2/R3/R4/R5/R6/R7/R8/R10", i), VEC[i][7:0]);
    end
    // R9: no write, state holds over several cycles
    wr_data = 16'h00FF; wr_sel = 1'b1;
    repeat (4) @(negedge clk);
    check("R9", 8'h0F);
    // R1: reset mid-run restores latches and zeroes config
    do_wr(1'b1, 16'h00FF);
    check("R3", 8'hF0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1", 8'hFF);
    do_wr(1'b1, 16'h0081);
    check("R1 config zero", 8'h7E);
    do_wr(1'b0, 16'h8080);
    check("R5 single pin", 8'hFE);
    do_wr(1'b0, 16'h0080);
    check("R6 single pin", 8'h7E);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule